// File: doc/BRIEF.md
# Dual-mode three-wire register write port

This block is the slave end of a simple register access link on a companion device. A host drives a strobe, an access clock and data lines. While the strobe is high, the block collects one 16-bit word on the rising edges of the access clock. The first eight bits are a register address and the last eight bits are the value to write. When the word is complete, the block issues a single write into a small register bank.

A mode input chooses how the bits travel. In serial mode, one data line carries the word, most significant bit first, over sixteen clock edges. In parallel mode, an 8-bit bus carries the address byte and then the data byte over two edges. All inputs are asynchronous to the system clock. They pass through two-flop synchronisers, and the access-clock edges are found from the synchronised samples.

Top module: `regacc_slave`

## Requirements
- R1: During and after reset, `wr_en_o` is 0 and `wr_addr_o` and `wr_data_o` are 0 until the first completed transfer.
- R2: With `mode_i` = 0 (parallel), a transfer takes two rising edges of `acc_clk_i` while `acc_strobe_i` is high. The bus value at the first edge is the address and the value at the second edge is the data. After the second edge the block issues one write with that address and data.
- R3: With `mode_i` = 1 (serial), a transfer takes sixteen rising edges of `acc_clk_i` with data on `acc_data_i[0]`, most significant bit first. Bits 15..8 form the address and bits 7..0 form the data.
- R4: Access-clock edges and data activity while `acc_strobe_i` is low are ignored. They produce no write and no change on `wr_addr_o` or `wr_data_o`.
- R5: If the strobe falls before a full word is collected, the transfer is aborted with no write. The next strobe-high period starts a fresh, aligned word.
- R6: `wr_en_o` is high for exactly one system clock cycle per completed word. `wr_addr_o` and `wr_data_o` change only in that cycle and hold their values otherwise.
- R7: Data is taken at the rising edge of the access clock. Changing the data lines while the access clock is high does not alter the captured word.
- R8: In serial mode, `acc_data_i[7:1]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Transfer style: 0 parallel, 1 serial |
| acc_strobe_i | input | 1 | Port select, active high |
| acc_clk_i | input | 1 | Access clock; data is captured on its rising edge |
| acc_data_i | input | 8 | Parallel data bus; bit 0 is the serial line |
| wr_en_o | output | 1 | One-cycle write pulse |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 8 | Value of the write |

## Verification
The bench sends words with the strobe low and expects nothing. A design that did not gate on the strobe would write garbage there.

It drops the strobe after a partial word and then sends a full one. A counter that survived the abort would write early or misaligned data.

It toggles the data lines while the access clock is high. It also drives noise on the unused bus bits in serial mode. Capturing on the wrong edge, or taking data from the wrong bit, would corrupt the result.

The bench also counts write pulses and their width. This catches a strobe that repeats or stretches.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } mode_e;
endpackage

// File: rtl/regacc_sync.sv
module regacc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/regacc_edge.sv
module regacc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_s_i,
  input  logic aclk_s_i,
  output logic stb_rise_o,
  output logic aclk_rise_o
);
  logic stb_q, aclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      aclk_q <= 1'b0;
    end else begin
      stb_q  <= stb_s_i;
      aclk_q <= aclk_s_i;
    end
  end

  assign stb_rise_o  = stb_s_i & ~stb_q;
  assign aclk_rise_o = aclk_s_i & ~aclk_q;
endmodule

// File: rtl/regacc_collect.sv
module regacc_collect #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regacc_pkg::mode_e mode_i,
  input  logic              stb_i,
  input  logic              stb_rise_i,
  input  logic              aclk_rise_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import regacc_pkg::*;

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int PBEATS = WORD_W / BUS_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] SER_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(PBEATS - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, base;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              done;
  logic [CNT_W-1:0]  last;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    done  = 1'b0;
    base  = stb_rise_i ? '0 : cnt_q;
    last  = (mode_i == MODE_SER) ? SER_LAST : PAR_LAST;
    if (!stb_i || stb_rise_i) cnt_d = '0;
    if (stb_i && aclk_rise_i) begin
      if (mode_i == MODE_SER) sh_d = {sh_q[WORD_W-2:0], data_i[0]};
      else                    sh_d = {sh_q[WORD_W-BUS_W-1:0], data_i};
      if (base == last) begin
        done  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      wr_en_o <= done;
      if (done) begin
        wr_addr_o <= sh_d[WORD_W-1:DATA_W];
        wr_data_o <= sh_d[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/regacc_slave.sv
module regacc_slave #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              acc_strobe_i,
  input  logic              acc_clk_i,
  input  logic [BUS_W-1:0]  acc_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import regacc_pkg::*;

  localparam int SYNC_W = BUS_W + 3;

  logic [SYNC_W-1:0] sync_s;
  logic              stb_s, aclk_s, mode_s;
  logic [BUS_W-1:0]  data_s;
  logic              stb_rise, clk_rise;

  regacc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({mode_i, acc_strobe_i, acc_clk_i, acc_data_i}),
    .sync_o  (sync_s)
  );

  assign {mode_s, stb_s, aclk_s, data_s} = sync_s;

  regacc_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_s_i     (stb_s),
    .aclk_s_i    (aclk_s),
    .stb_rise_o  (stb_rise),
    .aclk_rise_o (clk_rise)
  );

  regacc_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_e'(mode_s)),
    .stb_i       (stb_s),
    .stb_rise_i  (stb_rise),
    .aclk_rise_i (clk_rise),
    .data_i      (data_s),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o)
  );
endmodule

// File: rtl/regacc_slave_chk.sv
module regacc_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              stb_s,
  input logic              clk_rise
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  a_r4_write_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(stb_s));

  a_r2_write_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(clk_rise));

  a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wr_addr_o) || !$stable(wr_data_o)) |-> wr_en_o);
endmodule

bind regacc_slave regacc_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .stb_s     (stb_s),
  .clk_rise  (clk_rise)
);

// File: tb/regacc_slave_tb_top.sv
`timescale 1ns/1ps
module regacc_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b0;
  logic       acc_strobe_i = 1'b0;
  logic       acc_clk_i = 1'b0;
  logic [7:0] acc_data_i = 8'h00;
  logic       wr_en_o;
  logic [7:0] wr_addr_o, wr_data_o;

  int n_chk = 0, n_bad = 0;
  int pulses = 0, long_pulse = 0;
  logic       prev_en = 1'b0;
  logic [7:0] last_addr = 8'h00, last_data = 8'h00;

  always #5 clk = ~clk;

  regacc_slave dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .acc_strobe_i(acc_strobe_i),
    .acc_clk_i(acc_clk_i), .acc_data_i(acc_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(negedge clk) begin
    if (wr_en_o) begin
      pulses++;
      last_addr = wr_addr_o;
      last_data = wr_data_o;
      if (prev_en) long_pulse++;
    end
    prev_en = wr_en_o;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send beats of a word; nbeats may be short (abort). wiggle changes data while clock high.
  task automatic send(input logic ser, input logic [15:0] word, input int nbeats,
                      input logic gate, input logic wiggle);
    mode_i = ser;
    wait_clk(4);
    acc_strobe_i = gate;
    wait_clk(4);
    for (int b = 0; b < nbeats; b++) begin
      if (ser) acc_data_i = {~word[7:1] ^ 7'(b), word[15 - b]};
      else     acc_data_i = (b == 0) ? word[15:8] : word[7:0];
      wait_clk(4);
      acc_clk_i = 1'b1;
      wait_clk(4);
      if (wiggle) acc_data_i = ~acc_data_i;
      wait_clk(2);
      acc_clk_i = 1'b0;
      wait_clk(4);
    end
    wait_clk(4);
    acc_strobe_i = 1'b0;
    wait_clk(8);
  endtask

  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'h12A5}, {1'b0, 16'hFF00}, {1'b0, 16'h00FF},
    {1'b1, 16'h3C81}, {1'b1, 16'h8001}, {1'b1, 16'hA55A}
  };

  initial begin
    int p0;
    #10000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p0;
    wait_clk(3);
    check("R1 reset wr_en", wr_en_o, 0);
    check("R1 reset addr", wr_addr_o, 0);
    check("R1 reset data", wr_data_o, 0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1 idle after reset", pulses, 0);

    for (int i = 0; i < NV; i++) begin
      p0 = pulses;
      send(VEC[i][16], VEC[i][15:0], VEC[i][16] ? 16 : 2, 1'b1, 1'b0);
      check(VEC[i][16] ? "R3 serial pulse count" : "R2 parallel pulse count", pulses - p0, 1);
      check(VEC[i][16] ? "R3 serial addr" : "R2 parallel addr", last_addr, VEC[i][15:8]);
      check(VEC[i][16] ? "R8 serial data" : "R2 parallel data", last_data, VEC[i][7:0]);
    end

    // R4: activity with strobe low
    p0 = pulses;
    send(1'b0, 16'h7734, 2, 1'b0, 1'b0);
    send(1'b1, 16'h5AC3, 16, 1'b0, 1'b0);
    check("R4 no write strobe low", pulses - p0, 0);
    check("R4 addr held", wr_addr_o, 8'hA5);
    check("R4 data held", wr_data_o, 8'h5A);

    // R5: abort then aligned transfer
    p0 = pulses;
    send(1'b0, 16'hEE11, 1, 1'b1, 1'b0);
    send(1'b1, 16'hDDCC, 9, 1'b1, 1'b0);
    check("R5 abort no write", pulses - p0, 0);
    send(1'b0, 16'h4263, 2, 1'b1, 1'b0);
    check("R5 realigned count", pulses - p0, 1);
    check("R5 realigned addr", last_addr, 8'h42);
    check("R5 realigned data", last_data, 8'h63);

    // R7: data changes while access clock high
    p0 = pulses;
    send(1'b1, 16'hC30F, 16, 1'b1, 1'b1);
    check("R7 serial wiggle addr", last_addr, 8'hC3);
    check("R7 serial wiggle data", last_data, 8'h0F);
    send(1'b0, 16'h9B2E, 2, 1'b1, 1'b1);
    check("R7 parallel wiggle addr", last_addr, 8'h9B);
    check("R7 parallel wiggle data", last_data, 8'h2E);
    check("R7 pulse count", pulses - p0, 2);

    check("R6 single-cycle pulses", long_pulse, 0);
    check("R6 wr_en idle", wr_en_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule